// File: doc/BRIEF.md
# Quick-DMA Trigger Event Latch

This block captures transfer triggers for the eight channels of a quick-DMA controller. Each channel owns a mapping register that names one parameter-RAM entry and one word inside it. Any write that lands on that word raises the channel's pending flag. The write may come from the system bus or from the controller's own link-update path. A flag is raised only when the channel is enabled. A trigger that arrives while the flag is still up cannot be queued, so the block records it in a missed-trigger vector instead. Software clears that vector by writing ones to it.

Pending channels are offered one at a time on a valid/ready handshake, lowest channel number first. The flag of the offered channel drops on the cycle the request is accepted. When a new trigger for that channel arrives in the same cycle, the new trigger wins and the flag stays up. A small register port lets software set the mappings and the enable vector and read back all state.

Top module: `qdma_evt_latch`

## Requirements
- R1: After reset, the pending, missed and enable vectors and all eight mapping registers read 0, and `req_valid` is 0.
- R2: A mapping register holds a 12-bit value M: bits 11:3 select the entry and bits 2:0 select the word. Channel n's trigger address is M×4. A bus write whose 14-bit byte address equals this value exactly sets pending bit n on the next clock edge. Any other address leaves the bit unchanged.
- R3: A link-update write to a channel's trigger address sets that channel's pending bit, the same as a bus write does. A bus hit and a link hit on different channels in the same cycle set both bits.
- R4: A matching write to a channel whose enable bit is 0 leaves its pending bit unchanged.
- R5: One write sets the pending bit of every enabled channel that maps to the same trigger address.
- R6: `req_valid` is 1 whenever any channel is pending, and `req_chan` names the lowest-numbered pending channel. On a cycle with `req_valid` and `req_ready` both 1, that channel's pending bit clears.
- R7: If a channel's pending bit is cleared by acceptance and set by a trigger in the same cycle, the bit stays 1.
- R8: A trigger for an enabled channel whose pending bit is already 1 sets that channel's missed bit. This also applies when the same cycle accepts that channel.
- R9: Writing the missed register clears each bit written as 1. If a new miss occurs on a bit in the same cycle, that bit stays 1.
- R10: Register addresses 0 to 7 hold the mapping registers, address 8 the enable vector, address 9 the pending vector and address 10 the missed vector. Writes to address 9 have no effect. Bits 31:8 of the three vectors read 0.
- R11: Mapping registers read back the low 12 bits last written, and the enable register reads back the low 8 bits last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | System-bus write strobe into parameter RAM |
| bus_wr_addr | input | 14 | Byte address of the bus write |
| link_wr_en | input | 1 | Link-update write strobe from the controller |
| link_wr_addr | input | 14 | Byte address of the link-update write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0-7 mappings, 8 enable, 9 pending, 10 missed) |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | output | 1 | A pending channel is offered for submission |
| req_chan | output | 3 | Lowest-numbered pending channel |
| req_ready | input | 1 | Submission accepts the offered channel |

## Verification
The bench targets an acceptance that coincides with a new trigger for the same channel. A design that let the clear win would drop that trigger, and one that skipped the miss log would hide it. It also targets a W1C write that collides with a fresh miss, where a naive clear loses the miss. Two channels share one trigger address, which catches a design that sets only the first match. An address one byte off the trigger catches a compare that ignores the low bits. Writes to disabled channels and to the read-only pending register must leave the state unchanged. A randomized phase checks the registers and the handshake every cycle against a model built from the requirements.

// File: rtl/qdma_evt_pkg.sv
package qdma_evt_pkg;
    localparam int NUM_CH  = 8;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int ENTRY_W = 9;
    localparam int WORD_W  = 3;
    localparam int MAP_W   = ENTRY_W + WORD_W;
    localparam int ADDR_W  = MAP_W + 2;
    localparam int REG_AW  = 4;
    localparam int RDATA_W = 32;

    localparam logic [REG_AW-1:0] REG_ENABLE  = REG_AW'(NUM_CH);
    localparam logic [REG_AW-1:0] REG_PENDING = REG_AW'(NUM_CH + 1);
    localparam logic [REG_AW-1:0] REG_MISSED  = REG_AW'(NUM_CH + 2);

    typedef logic [NUM_CH-1:0] chvec_t;
    typedef logic [MAP_W-1:0]  map_t;

    typedef struct packed {
        chvec_t                 evt;
        chvec_t                 miss;
        chvec_t                 en;
        map_t [NUM_CH-1:0]      map;
    } ctl_state_t;
endpackage

// File: rtl/qdma_trig_match.sv
module qdma_trig_match
    import qdma_evt_pkg::*;
(
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  map_t [NUM_CH-1:0]     map,
    output chvec_t                hit
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [ADDR_W-1:0] trig_addr;
        assign trig_addr = {map[c], 2'b00};
        assign hit[c]    = wr_en && (wr_addr == trig_addr);
    end
endmodule

// File: rtl/qdma_prio_pick.sv
module qdma_prio_pick
    import qdma_evt_pkg::*;
(
    input  chvec_t            pend,
    output logic              valid,
    output logic [CH_W-1:0]   idx,
    output chvec_t            onehot
);
    always_comb begin
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = CH_W'(i);
            end
        end
    end

    assign valid  = |pend;
    assign onehot = pend & (~pend + chvec_t'(1));
endmodule

// File: rtl/qdma_reg_rd.sv
module qdma_reg_rd
    import qdma_evt_pkg::*;
(
    input  logic [REG_AW-1:0]   addr,
    input  ctl_state_t          st,
    output logic [RDATA_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (addr < REG_AW'(NUM_CH)) begin
            rdata[MAP_W-1:0] = st.map[addr[CH_W-1:0]];
        end else begin
            case (addr)
                REG_ENABLE:  rdata[NUM_CH-1:0] = st.en;
                REG_PENDING: rdata[NUM_CH-1:0] = st.evt;
                REG_MISSED:  rdata[NUM_CH-1:0] = st.miss;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/qdma_evt_latch.sv
module qdma_evt_latch
    import qdma_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic [ADDR_W-1:0]    bus_wr_addr,
    input  logic                 link_wr_en,
    input  logic [ADDR_W-1:0]    link_wr_addr,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [MAP_W-1:0]     reg_wdata,
    output logic [RDATA_W-1:0]   reg_rdata,
    output logic                 req_valid,
    output logic [CH_W-1:0]      req_chan,
    input  logic                 req_ready
);
    ctl_state_t state_q, state_d;

    chvec_t bus_hit, link_hit, qual, grant_oh, clr, w1c, lost;
    chvec_t evt_vec, miss_vec;

    assign evt_vec  = state_q.evt;
    assign miss_vec = state_q.miss;

    qdma_trig_match u_bus_match (
        .wr_en   (bus_wr_en),
        .wr_addr (bus_wr_addr),
        .map     (state_q.map),
        .hit     (bus_hit)
    );

    qdma_trig_match u_link_match (
        .wr_en   (link_wr_en),
        .wr_addr (link_wr_addr),
        .map     (state_q.map),
        .hit     (link_hit)
    );

    qdma_prio_pick u_pick (
        .pend    (state_q.evt),
        .valid   (req_valid),
        .idx     (req_chan),
        .onehot  (grant_oh)
    );

    qdma_reg_rd u_rd (
        .addr    (reg_addr),
        .st      (state_q),
        .rdata   (reg_rdata)
    );

    always_comb begin
        qual = (bus_hit | link_hit) & state_q.en;
        clr  = (req_valid && req_ready) ? grant_oh : '0;
        w1c  = (reg_we && reg_addr == REG_MISSED) ? reg_wdata[NUM_CH-1:0] : '0;
        lost = qual & state_q.evt;

        state_d      = state_q;
        state_d.evt  = (state_q.evt & ~clr) | qual;
        state_d.miss = (state_q.miss & ~w1c) | lost;
        if (reg_we && reg_addr == REG_ENABLE) begin
            state_d.en = reg_wdata[NUM_CH-1:0];
        end
        if (reg_we && reg_addr < REG_AW'(NUM_CH)) begin
            state_d.map[reg_addr[CH_W-1:0]] = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/qdma_evt_checker.sv
module qdma_evt_checker
    import qdma_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  chvec_t               qual,
    input  chvec_t               evt_q,
    input  chvec_t               miss_q,
    input  logic                 req_valid,
    input  logic                 req_ready,
    input  logic [CH_W-1:0]      req_chan,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [MAP_W-1:0]     reg_wdata,
    input  logic [RDATA_W-1:0]   reg_rdata
);
    // R6: offered channel is pending and no lower channel is pending
    a_r6_lowest_offer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (evt_q[req_chan] &&
                       ((evt_q & ((NUM_CH'(1) << req_chan) - NUM_CH'(1))) == '0)));

    // R6: accepted channel without a new trigger drops its bit
    a_r6_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !qual[req_chan]) |=> !evt_q[$past(req_chan)]);

    // R4: pending bits only rise from qualified triggers
    a_r4_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(qual)) == '0));

    // R7: a qualified trigger always leaves its bit set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (qual != '0) |=> ((evt_q & $past(qual)) == $past(qual)));

    // R8: trigger on a pending channel logs a miss
    a_r8_miss_logged: assert property (@(posedge clk) disable iff (!rst_n)
        ((qual & evt_q) != '0) |=> ((miss_q & $past(qual & evt_q)) == $past(qual & evt_q)));

    // R9: written-one bits clear when no new miss collides
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_MISSED && ((qual & evt_q) == '0))
        |=> ((miss_q & $past(reg_wdata[NUM_CH-1:0])) == '0));

    // R10: vector registers read zero above the channel bits
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_PENDING || reg_addr == REG_MISSED || reg_addr == REG_ENABLE)
        |-> (reg_rdata[RDATA_W-1:NUM_CH] == '0));
endmodule

bind qdma_evt_latch qdma_evt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual      (qual),
    .evt_q     (evt_vec),
    .miss_q    (miss_vec),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_chan  (req_chan),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/tb_qdma_evt_latch.sv
module tb_qdma_evt_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [13:0] bus_wr_addr = '0;
    logic        link_wr_en = 1'b0;
    logic [13:0] link_wr_addr = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [2:0]  req_chan;
    logic        req_ready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    qdma_evt_latch dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
        .link_wr_en(link_wr_en), .link_wr_addr(link_wr_addr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        be;
        logic [13:0] ba;
        logic        le;
        logic [13:0] la;
        logic        we;
        logic [3:0]  ra;
        logic [11:0] wd;
        logic        rdy;
        logic [7:0]  ev;
        logic [7:0]  ms;
    } vec_t;

    // Trigger addresses: ch0 044, ch1 088, ch2 0CC, ch3 110, ch4 154, ch5/ch6 198, ch7 1DC (disabled)
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{"R2 ", 1'b1, 14'h044, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b0, 8'h01, 8'h00},
        '{"R3 ", 1'b0, 14'h000, 1'b1, 14'h0CC, 1'b0, 4'd0,  12'h000, 1'b0, 8'h05, 8'h00},
        '{"R4 ", 1'b1, 14'h1DC, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b0, 8'h05, 8'h00},
        '{"R5 ", 1'b1, 14'h198, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b0, 8'h65, 8'h00},
        '{"R6 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h64, 8'h00},
        '{"R7 ", 1'b1, 14'h0CC, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h64, 8'h04},
        '{"R8 ", 1'b0, 14'h000, 1'b1, 14'h198, 1'b0, 4'd0,  12'h000, 1'b0, 8'h64, 8'h64},
        '{"R9 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b1, 4'd10, 12'h004, 1'b0, 8'h64, 8'h60},
        '{"R9 ", 1'b1, 14'h198, 1'b0, 14'h000, 1'b1, 4'd10, 12'h020, 1'b0, 8'h64, 8'h60},
        '{"R10", 1'b0, 14'h000, 1'b0, 14'h000, 1'b1, 4'd9,  12'h0FF, 1'b0, 8'h64, 8'h60},
        '{"R3 ", 1'b1, 14'h088, 1'b1, 14'h110, 1'b0, 4'd0,  12'h000, 1'b0, 8'h6E, 8'h60},
        '{"R6 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h6C, 8'h60},
        '{"R6 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h68, 8'h60},
        '{"R6 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h60, 8'h60},
        '{"R6 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h40, 8'h60},
        '{"R6 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h00, 8'h60},
        '{"R6 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b1, 8'h00, 8'h60},
        '{"R2 ", 1'b1, 14'h045, 1'b0, 14'h000, 1'b0, 4'd0,  12'h000, 1'b0, 8'h00, 8'h60},
        '{"R9 ", 1'b0, 14'h000, 1'b0, 14'h000, 1'b1, 4'd10, 12'h060, 1'b0, 8'h00, 8'h00}
    };

    logic [11:0] maps [8];
    logic [7:0]  m_evt, m_miss, m_en;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_wr_en = 1'b0; link_wr_en = 1'b0; reg_we = 1'b0; req_ready = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [11:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic be, input logic [13:0] ba, input logic le, input logic [13:0] la);
        @(negedge clk);
        bus_wr_en = be; bus_wr_addr = ba; link_wr_en = le; link_wr_addr = la;
        @(negedge clk);
        idle();
    endtask

    function automatic logic [7:0] hits(input logic [13:0] a);
        logic [7:0] h = '0;
        for (int c = 0; c < 8; c++) h[c] = (a == {maps[c], 2'b00});
        return h;
    endfunction

    function automatic logic [7:0] lowest(input logic [7:0] v);
        for (int c = 0; c < 8; c++) if (v[c]) return 8'(1 << c);
        return 8'h00;
    endfunction

    function automatic logic [2:0] lowest_idx(input logic [7:0] v);
        for (int c = 0; c < 8; c++) if (v[c]) return 3'(c);
        return 3'd0;
    endfunction

    task automatic random_block(input int cycles, input logic [7:0] enable);
        logic [31:0] d;
        logic [7:0] qual, clr, w1c;
        logic [13:0] ba, la;
        wr(4'd8, {4'h0, enable});
        m_en = enable;
        reg_addr = 4'd9;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            d = reg_rdata;
            chk(reg_addr == 4'd9 ? "R6 random pending" : "R8 random missed", d,
                {24'h0, (reg_addr == 4'd9) ? m_evt : m_miss});
            chk("R6 random offer", {28'h0, req_valid, req_chan},
                {28'h0, (m_evt != 0), lowest_idx(m_evt)});
            ba = ($urandom_range(0, 3) == 0) ? 14'($urandom) : {maps[$urandom_range(0, 7)], 2'b00};
            la = ($urandom_range(0, 3) == 0) ? 14'($urandom) : {maps[$urandom_range(0, 7)], 2'b00};
            bus_wr_en    = ($urandom_range(0, 2) == 0);
            link_wr_en   = ($urandom_range(0, 4) == 0);
            bus_wr_addr  = ba;
            link_wr_addr = la;
            req_ready    = ($urandom_range(0, 2) != 0);
            reg_we       = ($urandom_range(0, 5) == 0);
            reg_wdata    = 12'($urandom);
            reg_addr     = reg_we ? 4'd10 : (($urandom_range(0, 1) == 0) ? 4'd9 : 4'd10);
            qual = ((bus_wr_en ? hits(ba) : 8'h0) | (link_wr_en ? hits(la) : 8'h0)) & m_en;
            clr  = req_ready ? lowest(m_evt) : 8'h0;
            w1c  = reg_we ? reg_wdata[7:0] : 8'h0;
            m_miss = (m_miss & ~w1c) | (qual & m_evt);
            m_evt  = (m_evt & ~clr) | qual;
        end
        @(negedge clk);
        idle();
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(4'd9, d);  chk("R1 pending", d, 32'h0);
        rd(4'd10, d); chk("R1 missed", d, 32'h0);
        rd(4'd8, d);  chk("R1 enable", d, 32'h0);
        rd(4'd3, d);  chk("R1 map3", d, 32'h0);
        chk("R1 req_valid", {31'h0, req_valid}, 32'h0);

        maps = '{12'h011, 12'h022, 12'h033, 12'h044, 12'h055, 12'h066, 12'h066, 12'h077};
        for (int c = 0; c < 8; c++) wr(4'(c), maps[c]);
        wr(4'd8, 12'h07F);

        // R11: readback of configuration
        rd(4'd6, d); chk("R11 map6", d, 32'h066);
        rd(4'd8, d); chk("R11 enable", d, 32'h07F);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr_en = VEC[i].be; bus_wr_addr = VEC[i].ba;
            link_wr_en = VEC[i].le; link_wr_addr = VEC[i].la;
            reg_we = VEC[i].we; reg_addr = VEC[i].ra; reg_wdata = VEC[i].wd;
            req_ready = VEC[i].rdy;
            @(negedge clk);
            idle();
            rd(4'd9, d);  chk($sformatf("%s step %0d pending", VEC[i].tag, i), d, {24'h0, VEC[i].ev});
            rd(4'd10, d); chk($sformatf("%s step %0d missed", VEC[i].tag, i), d, {24'h0, VEC[i].ms});
        end

        // R11: field masking on readback
        wr(4'd0, 12'hFFF);
        rd(4'd0, d); chk("R11 map full width", d, 32'h0000_0FFF);
        wr(4'd0, maps[0]);

        // R6: lowest pending offered
        pulse(1'b1, 14'h110, 1'b1, 14'h1DC);
        chk("R6 offer ch3", {28'h0, req_valid, req_chan}, {28'h0, 1'b1, 3'd3});
        pulse(1'b1, 14'h088, 1'b0, 14'h000);
        chk("R6 offer ch1", {28'h0, req_valid, req_chan}, {28'h0, 1'b1, 3'd1});

        // R4: enable cleared at runtime blocks triggers
        wr(4'd8, 12'h000);
        pulse(1'b1, 14'h044, 1'b1, 14'h0CC);
        rd(4'd9, d); chk("R4 disabled pending", d, 32'h0000_000A);
        rd(4'd10, d); chk("R4 disabled missed", d, 32'h0);

        // R10: upper bits of pending read zero
        rd(4'd9, d); chk("R10 upper zero", {d[31:8], 8'h00}, 32'h0);

        // Drain, then randomized phase with model
        @(negedge clk); req_ready = 1'b1;
        repeat (4) @(negedge clk);
        req_ready = 1'b0;
        wr(4'd10, 12'h0FF);
        m_evt = 8'h00; m_miss = 8'h00;
        random_block(400, 8'h7F);
        random_block(400, 8'hA5);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule